// File: doc/BRIEF.md
# MSI Snooping Line Coherence Controller

This block keeps the coherence state of one line in a write-back cache that sits on a shared broadcast bus. A line is Invalid, Shared (a clean read-only copy that other caches may also hold) or Modified (the single dirty copy, which may be read and written). The controller receives two streams of events. The processor side issues read, write and write-back (eviction). The bus side reports what other caches are doing: a remote read miss or a remote write miss. In response it raises the bus transaction the line needs, pulses a data-supply strobe when it hands over its dirty copy, and tells the processor when its access has completed.

A processor access that cannot finish locally raises a bus request. The request is combinational and stays up while the processor holds its access. The bus owner answers with a grant in any cycle the request is high, and the state changes at the clock edge that ends the grant cycle. A snoop and a processor event can arrive in the same cycle. In that case the snoop is applied to the line first, and the processor event is then decided against the state the snoop leaves behind. The tag and data arrays, replacement choice, bus arbitration and memory sit outside the block.

Top module: `msi_line_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the line reads Invalid, with no bus request and no data strobe. The encodings are: `line_state` 0 = Invalid, 1 = Shared, 2 = Modified; `cpu_op` 0 = read, 1 = write, 2 = write-back, 3 = no-op that completes at once; `snoop_op` 0 = remote read, 1 = remote write; `bus_cmd` 0 = bus read, 1 = bus write, 2 = upgrade/invalidate.
- R2: A read to an Invalid line requests a bus read (`bus_cmd` 0). The read completes in the grant cycle, and the line is Shared from the next cycle.
- R3: A write to an Invalid line requests a bus write (`bus_cmd` 1). The write completes in the grant cycle, and the line is Modified from the next cycle. The line never becomes Modified except through a completed write.
- R4: A write to a Shared line requests an upgrade (`bus_cmd` 2). The write completes in the grant cycle, and the line is Modified from the next cycle.
- R5: A read to a Shared or Modified line, and a write to a Modified line, complete in the same cycle. They raise no bus request and leave the state as it is.
- R6: A remote read seen while Modified pulses `send_data` in that cycle and leaves the line Shared. A remote read seen while Shared or Invalid has no effect.
- R7: A remote write seen while Modified pulses `send_data` and leaves the line Invalid. Seen while Shared, it leaves the line Invalid without a data strobe. Seen while Invalid, it has no effect.
- R8: A write-back completes in the same cycle and never requests the bus. From Modified it pulses `send_data`, and from any state it leaves the line Invalid.
- R9: While a request waits without a grant, `cpu_ready` stays low and the state is unchanged. A grant with no request pending has no effect.
- R10: When a snoop and a processor event arrive in the same cycle, the snoop is applied first. The processor event is then judged against the resulting state. For example, a pending upgrade hit by a remote write turns into a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor event present; held until `cpu_ready` |
| cpu_op | input | 2 | Processor event kind (see R1) |
| cpu_ready | output | 1 | Processor event completes this cycle |
| snoop_valid | input | 1 | Remote bus event observed this cycle |
| snoop_op | input | 1 | Remote event kind: 0 read, 1 write |
| bus_req | output | 1 | Bus transaction wanted this cycle |
| bus_cmd | output | 2 | Transaction kind while `bus_req` is high, else 0 |
| bus_gnt | input | 1 | Grant for the current request |
| send_data | output | 1 | Dirty line is supplied this cycle |
| line_state | output | 2 | Current coherence state |

## Verification
The assertions assume that a processor event, once raised, is held with the same operation until `cpu_ready`, and that snoops and grants may arrive in any cycle, including together with a processor event. The directed part of the stimulus keeps each access held until it completes. The mixed part picks a new access only after the previous one has completed, and it drives snoops and grants freely, so every snoop/local collision order and every stray grant is reached. No rule forbids a grant with no request, and such grants are driven on purpose to show that they have no effect.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int ST_W  = 2;
  localparam int OP_W  = 2;
  localparam int CMD_W = 2;

  typedef enum logic [ST_W-1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [OP_W-1:0] {
    PE_READ  = 2'd0,
    PE_WRITE = 2'd1,
    PE_EVICT = 2'd2,
    PE_NOP   = 2'd3
  } proc_ev_e;

  typedef enum logic [CMD_W-1:0] {
    BC_READ  = 2'd0,
    BC_WRITE = 2'd1,
    BC_UPGR  = 2'd2
  } bus_cmd_e;

  localparam logic SN_RD = 1'b0;
  localparam logic SN_WR = 1'b1;
endpackage

// File: rtl/msi_snoop_apply.sv
module msi_snoop_apply
  import msi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  line_st_e cur_st,
  input  logic     snp_valid,
  input  logic     snp_op,
  output line_st_e post_st,
  output logic     snp_supply
);
  always_comb begin
    post_st    = cur_st;
    snp_supply = 1'b0;
    if (snp_valid) begin
      unique case (cur_st)
        LS_MOD: begin
          snp_supply = 1'b1;
          post_st    = (snp_op == SN_RD) ? LS_SHR : LS_INV;
        end
        LS_SHR: begin
          if (snp_op == SN_WR) post_st = LS_INV;
        end
        default: post_st = cur_st;
      endcase
    end
  end

  // R7: a remote write always leaves no valid copy behind
  a_r7_remote_write_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == SN_WR) |-> (post_st == LS_INV));

  // R6: a remote read never leaves the line Modified
  a_r6_remote_read_demotes: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == SN_RD) |-> (post_st != LS_MOD));
endmodule

// File: rtl/msi_local_eval.sv
module msi_local_eval
  import msi_pkg::*;
(
  input  line_st_e          post_st,
  input  logic              ev_valid,
  input  logic [OP_W-1:0]   ev_op,
  output logic              need_bus,
  output logic [CMD_W-1:0]  need_cmd,
  output logic              hit_done,
  output line_st_e          done_st,
  output logic              evict_supply
);
  always_comb begin
    need_bus     = 1'b0;
    need_cmd     = BC_READ;
    hit_done     = 1'b0;
    done_st      = post_st;
    evict_supply = 1'b0;
    if (ev_valid) begin
      unique case (proc_ev_e'(ev_op))
        PE_READ: begin
          if (post_st == LS_INV) begin
            need_bus = 1'b1;
            need_cmd = BC_READ;
            done_st  = LS_SHR;
          end else begin
            hit_done = 1'b1;
          end
        end
        PE_WRITE: begin
          if (post_st == LS_MOD) begin
            hit_done = 1'b1;
          end else begin
            need_bus = 1'b1;
            need_cmd = (post_st == LS_INV) ? BC_WRITE : BC_UPGR;
            done_st  = LS_MOD;
          end
        end
        PE_EVICT: begin
          hit_done     = 1'b1;
          done_st      = LS_INV;
          evict_supply = (post_st == LS_MOD);
        end
        default: hit_done = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/msi_bus_hs.sv
module msi_bus_hs
  import msi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             need_bus,
  input  logic [CMD_W-1:0] need_cmd,
  input  logic             gnt,
  output logic             req,
  output logic [CMD_W-1:0] cmd,
  output logic             granted
);
  always_comb begin
    req     = need_bus;
    cmd     = need_bus ? need_cmd : '0;
    granted = need_bus & gnt;
  end

  // R9: no transaction is taken without a grant
  a_r9_wait_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |-> !granted);

  // R9: a stray grant alone never completes anything
  a_r9_stray_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !req) |-> !granted);
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  output logic             cpu_ready,
  input  logic             snoop_valid,
  input  logic             snoop_op,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  input  logic             bus_gnt,
  output logic             send_data,
  output logic [1:0]       line_state
);
  line_st_e         st_q, st_d, post_st, done_st;
  logic             st_en;
  logic             snp_supply, evict_supply;
  logic             need_bus, hit_done, granted, commit;
  logic [CMD_W-1:0] need_cmd;

  msi_snoop_apply u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_st     (st_q),
    .snp_valid  (snoop_valid),
    .snp_op     (snoop_op),
    .post_st    (post_st),
    .snp_supply (snp_supply)
  );

  msi_local_eval u_local (
    .post_st      (post_st),
    .ev_valid     (cpu_valid),
    .ev_op        (cpu_op),
    .need_bus     (need_bus),
    .need_cmd     (need_cmd),
    .hit_done     (hit_done),
    .done_st      (done_st),
    .evict_supply (evict_supply)
  );

  msi_bus_hs u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .need_bus (need_bus),
    .need_cmd (need_cmd),
    .gnt      (bus_gnt),
    .req      (bus_req),
    .cmd      (bus_cmd),
    .granted  (granted)
  );

  // next-state process
  always_comb begin
    commit = hit_done | granted;
    st_d   = commit ? done_st : post_st;
    st_en  = (st_d != st_q);
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= LS_INV;
    else if (st_en) st_q <= st_d;
  end

  assign cpu_ready  = commit;
  assign send_data  = snp_supply | evict_supply;
  assign line_state = st_q;

  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    line_state != 2'd3);

  a_r2_bus_read_from_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_READ && !snoop_valid) |-> (line_state == LS_INV));

  a_r3_mod_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state != LS_MOD && !(cpu_valid && cpu_op == PE_WRITE && cpu_ready))
      |=> (line_state != LS_MOD));

  a_r4_upgrade_from_shr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_UPGR && !snoop_valid) |-> (line_state == LS_SHR));

  a_r5_mod_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_MOD && !snoop_valid && cpu_valid && cpu_op == PE_READ)
      |-> (!bus_req && cpu_ready));

  a_r6_supply_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    send_data |-> (line_state == LS_MOD));

  a_r8_evict_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_op == PE_EVICT) |-> (!bus_req && cpu_ready));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_valid && !snoop_valid) |=> $stable(line_state));

  a_r10_upgrade_becomes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_SHR && snoop_valid && snoop_op == SN_WR && cpu_valid && cpu_op == PE_WRITE)
      |-> (bus_req && bus_cmd == BC_WRITE));
endmodule

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic       snoop_valid = 1'b0;
  logic       snoop_op = 1'b0;
  logic       bus_gnt = 1'b0;
  logic       cpu_ready, bus_req, send_data;
  logic [1:0] bus_cmd, line_state;

  int checks = 0;
  int errors = 0;
  int ref_st = 0;   // 0 Invalid, 1 Shared, 2 Modified

  always #4 clk = ~clk;

  msi_line_ctrl u_msi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_gnt(bus_gnt),
    .send_data(send_data), .line_state(line_state)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, predict, compare, advance the model
  task automatic step(input string tag, input bit cv, input int cop,
                      input bit sv, input bit sop, input bit g);
    int mid, nxt, rq, cm, rdy, sd;
    @(negedge clk);
    cpu_valid = cv; cpu_op = cop[1:0];
    snoop_valid = sv; snoop_op = sop; bus_gnt = g;
    #2;
    sd = 0; mid = ref_st;
    if (sv && ref_st == 2) begin sd = 1; mid = sop ? 0 : 1; end
    else if (sv && sop && ref_st == 1) mid = 0;
    nxt = mid; rq = 0; cm = 0; rdy = 0;
    if (cv) begin
      if (cop == 0) begin
        if (mid == 0) begin rq = 1; cm = 0; if (g) begin rdy = 1; nxt = 1; end end
        else rdy = 1;
      end else if (cop == 1) begin
        if (mid == 2) rdy = 1;
        else begin rq = 1; cm = (mid == 0) ? 1 : 2; if (g) begin rdy = 1; nxt = 2; end end
      end else if (cop == 2) begin
        rdy = 1; nxt = 0; if (mid == 2) sd = 1;
      end else rdy = 1;
    end
    check(tag, "line_state", int'(line_state), ref_st);
    check(tag, "cpu_ready", int'(cpu_ready), rdy);
    check(tag, "bus_req", int'(bus_req), rq);
    if (rq) check(tag, "bus_cmd", int'(bus_cmd), cm);
    check(tag, "send_data", int'(send_data), sd);
    @(posedge clk);
    ref_st = nxt;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    check("R1", "line_state in reset", int'(line_state), 0);
    check("R1", "bus_req in reset", int'(bus_req), 0);
    check("R1", "send_data in reset", int'(send_data), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);
    // R2 read miss held, then granted
    step("R9", 1, 0, 0, 0, 0);
    step("R9", 1, 0, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 1);
    step("R5", 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0);
    step("R4", 1, 1, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 1);
    step("R5", 1, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0);
    step("R7", 0, 0, 1, 1, 0);
    step("R7", 0, 0, 1, 1, 0);
    step("R6", 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 1);
    step("R3", 1, 1, 0, 0, 1);
    step("R7", 0, 0, 1, 1, 0);
    step("R3", 1, 1, 0, 0, 1);
    step("R8", 1, 2, 0, 0, 0);
    step("R8", 1, 2, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 1);
    step("R8", 1, 2, 0, 0, 0);
    step("R1", 1, 3, 0, 0, 0);
    // R10 collisions
    step("R2", 1, 0, 0, 0, 1);
    step("R10", 1, 1, 0, 0, 0);
    step("R10", 1, 1, 1, 1, 0);
    step("R10", 1, 1, 0, 0, 1);
    step("R10", 1, 1, 1, 0, 0);
    step("R10", 1, 1, 0, 0, 1);
    step("R10", 1, 2, 1, 0, 0);
    step("R10", 1, 0, 1, 1, 1);
    // mixed stimulus, accesses held until completion
    begin
      bit held = 0;
      int hop = 0;
      for (int i = 0; i < 600; i++) begin
        bit cv;
        if (!held) begin
          cv = ($urandom % 3) != 0;
          hop = $urandom % 4;
        end else cv = 1;
        held = cv;
        step("R10", cv, hop, ($urandom % 3) == 0, $urandom % 2, ($urandom % 2) == 1);
        if (cpu_ready) held = 0;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule